// File: doc/BRIEF.md
# Serial Control-Word Loader with Latch Decode

This block takes 24-bit control words from a write-only three-wire serial port (shift clock, data, load strobe) and files each word into one of four holding latches. The two least significant bits of the word choose the target. The serial pins are sampled in the system clock domain: each pin passes through a synchronizer, and an edge detector finds the shift and load events. The block drives every decoded field of the divider, swallow/main-count and function latches as separate outputs.

Writing the initialization target also fills the function latch and arms a one-shot counter reset. The reset pulse fires at the initialization write itself. It fires once more on the first swallow/main-count write that follows. Later writes of that kind leave it low until another initialization write re-arms it. The downstream divider counters and the timeout counter use this pulse to restart in alignment.

Top module: `ser_cfg_loader`

## Requirements
- R1: The data pin is shifted in most significant bit first, one bit per rising edge of the shift clock. Only the last 24 bits shifted before the load edge form the word.
- R2: Each rising edge of the load pin transfers the word to the latch selected by word bits [1:0]: 0 = divider latch, 1 = count latch, 2 = function latch, 3 = initialization. The latches that are not selected keep their contents.
- R3: Divider latch fields: divide ratio = word[15:2] (14 bits), anti-backlash code = word[17:16], test bits = word[19:18], lock-detect precision = word[20]. Bits [23:21] are ignored.
- R4: Count latch fields: swallow count A = word[7:2], main count B = word[20:8], gain bit = word[21]. Bits [23:22] are ignored.
- R5: Function latch fields: counter reset = bit 2, power-down 1 = bit 3, output select = [6:4], detector polarity = bit 7, pump three-state = bit 8, fast-lock enable = bit 9, fast-lock mode = bit 10, timer code = [14:11], current 1 = [17:15], current 2 = [20:18], power-down 2 = bit 21, prescaler select = [23:22].
- R6: An initialization write loads the function latch with the same field layout as R5 and raises `ctr_rst_pulse`.
- R7: The first count-latch write after an initialization write raises `ctr_rst_pulse`. Further count-latch writes do not raise it until a new initialization write occurs.
- R8: Divider and function latch writes never raise `ctr_rst_pulse`. A count-latch write made before any initialization write does not raise it either.
- R9: Words keep being accepted and latched while the function latch has power-down 1 and power-down 2 set.
- R10: After reset every latch field is zero and `ctr_rst_pulse` is low.
- R11: `ctr_rst_pulse` is high for exactly one system clock cycle per triggering write.
- R12: Holding the load pin high transfers nothing further: shifting during that time changes no latch until the pin falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data (asynchronous) |
| ser_load | input | 1 | Serial load strobe (asynchronous) |
| r_div | output | 14 | Reference divide ratio |
| r_abw | output | 2 | Anti-backlash width code |
| r_test | output | 2 | Test-mode bits |
| r_ldp | output | 1 | Lock-detect precision |
| ab_a | output | 6 | Swallow count A |
| ab_b | output | 13 | Main count B |
| ab_gain | output | 1 | Pump gain bit (fast-lock start) |
| fn_cnt_rst | output | 1 | Counter reset bit |
| fn_pd1 | output | 1 | Power-down 1 |
| fn_mux | output | 3 | Output select |
| fn_pol | output | 1 | Detector polarity |
| fn_cp3s | output | 1 | Pump three-state |
| fn_fl_en | output | 1 | Fast-lock enable |
| fn_fl_mode | output | 1 | Fast-lock mode |
| fn_timer | output | 4 | Fast-lock timer code |
| fn_cur1 | output | 3 | Pump current setting 1 |
| fn_cur2 | output | 3 | Pump current setting 2 |
| fn_pd2 | output | 1 | Power-down 2 |
| fn_presc | output | 2 | Prescaler select |
| ctr_rst_pulse | output | 1 | One-cycle counter reset pulse |

## Verification
A sequence of words runs through all four targets in an order meant to tell the reset-pulse rules apart. A count write comes before any initialization and must stay quiet. Two count writes follow an initialization and only the first may pulse. A function write sits between an initialization and a count write, to show that it neither consumes nor clears the arming. All-ones and all-zeros words, and words with the ignored top bits set, separate correct field slicing from shifted or truncated slicing. Directed cases cover leading extra bits, a load pin held high while a second word is shifted, and writes made while both power-down bits are set.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
    localparam int WORD_W = 24;
    localparam int SEL_W  = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_RDIV = 2'd0,
        SEL_CNT  = 2'd1,
        SEL_FUNC = 2'd2,
        SEL_INIT = 2'd3
    } sel_e;

    // word[20:2]
    typedef struct packed {
        logic        ldp;
        logic [1:0]  test;
        logic [1:0]  abw;
        logic [13:0] rdiv;
    } rlat_t;

    // word[21:2]
    typedef struct packed {
        logic        gain;
        logic [12:0] b;
        logic [5:0]  a;
    } cntlat_t;

    // word[23:2]
    typedef struct packed {
        logic [1:0] presc;
        logic       pd2;
        logic [2:0] cur2;
        logic [2:0] cur1;
        logic [3:0] timer;
        logic       fl_mode;
        logic       fl_en;
        logic       cp3s;
        logic       pol;
        logic [2:0] mux;
        logic       pd1;
        logic       cnt_rst;
    } fnlat_t;

    localparam int RLAT_W = $bits(rlat_t);
    localparam int CLAT_W = $bits(cntlat_t);
    localparam int FLAT_W = $bits(fnlat_t);
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
        logic [WIDTH-1:0]             last;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
        st_d.last = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.chain[STAGES-1];
    assign rise  = st_q.chain[STAGES-1] & ~st_q.last;

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_chk
            // R12
            edge_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                rise[g] |=> !rise[g]);
        end
    endgenerate
endmodule

// File: rtl/ser_shift.sv
module ser_shift #(
    parameter int W = cfg_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] word
);
    typedef struct packed {
        logic [W-1:0] sr;
    } sh_st_t;

    sh_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) st_d.sr = {st_q.sr[W-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word = st_q.sr;

    // R1
    shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (word[0] == $past(din)) && (word[W-1:1] == $past(word[W-2:0])));
    // R1
    shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(word));
endmodule

// File: rtl/cfg_latches.sv
module cfg_latches
    import cfg_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_stb,
    input  logic [W-1:0] word,
    output rlat_t        r_lat,
    output cntlat_t      c_lat,
    output fnlat_t       f_lat,
    output logic         rst_pulse
);
    localparam int R_HI = SEL_W + RLAT_W - 1;
    localparam int C_HI = SEL_W + CLAT_W - 1;
    localparam int F_HI = SEL_W + FLAT_W - 1;

    typedef struct packed {
        rlat_t   r;
        cntlat_t c;
        fnlat_t  f;
        logic    armed;
        logic    pulse;
    } lat_st_t;

    lat_st_t st_d, st_q;
    sel_e    sel;

    assign sel = sel_e'(word[SEL_W-1:0]);

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (load_stb) begin
            unique case (sel)
                SEL_RDIV: st_d.r = rlat_t'(word[R_HI:SEL_W]);
                SEL_CNT: begin
                    st_d.c = cntlat_t'(word[C_HI:SEL_W]);
                    if (st_q.armed) begin
                        st_d.pulse = 1'b1;
                        st_d.armed = 1'b0;
                    end
                end
                SEL_FUNC: st_d.f = fnlat_t'(word[F_HI:SEL_W]);
                SEL_INIT: begin
                    st_d.f     = fnlat_t'(word[F_HI:SEL_W]);
                    st_d.pulse = 1'b1;
                    st_d.armed = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign r_lat     = st_q.r;
    assign c_lat     = st_q.c;
    assign f_lat     = st_q.f;
    assign rst_pulse = st_q.pulse;

    // R2
    r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load_stb) |-> $stable(r_lat) && $stable(c_lat) && $stable(f_lat));
    // R6
    init_fn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && sel == SEL_INIT) |=> (f_lat == $past(word[F_HI:SEL_W])) && rst_pulse);
    // R7
    arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && sel == SEL_CNT && st_q.armed) |=> rst_pulse && !st_q.armed);
    // R8
    quiet_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && (sel == SEL_RDIV || sel == SEL_FUNC)) |=> !rst_pulse);
    // R11
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |=> !rst_pulse);
endmodule

// File: rtl/ser_cfg_loader.sv
module ser_cfg_loader
    import cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ser_clk,
    input  logic        ser_data,
    input  logic        ser_load,
    output logic [13:0] r_div,
    output logic [1:0]  r_abw,
    output logic [1:0]  r_test,
    output logic        r_ldp,
    output logic [5:0]  ab_a,
    output logic [12:0] ab_b,
    output logic        ab_gain,
    output logic        fn_cnt_rst,
    output logic        fn_pd1,
    output logic [2:0]  fn_mux,
    output logic        fn_pol,
    output logic        fn_cp3s,
    output logic        fn_fl_en,
    output logic        fn_fl_mode,
    output logic [3:0]  fn_timer,
    output logic [2:0]  fn_cur1,
    output logic [2:0]  fn_cur2,
    output logic        fn_pd2,
    output logic [1:0]  fn_presc,
    output logic        ctr_rst_pulse
);
    localparam int PIN_N  = 3;
    localparam int P_CLK  = 0;
    localparam int P_DATA = 1;
    localparam int P_LOAD = 2;

    logic [PIN_N-1:0]  pin_lvl, pin_rise;
    logic [WORD_W-1:0] word;
    rlat_t             r_lat;
    cntlat_t           c_lat;
    fnlat_t            f_lat;

    edge_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ser_load, ser_data, ser_clk}),
        .level    (pin_lvl),
        .rise     (pin_rise)
    );

    ser_shift #(.W(WORD_W)) shift_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (pin_rise[P_CLK]),
        .din      (pin_lvl[P_DATA]),
        .word     (word)
    );

    cfg_latches #(.W(WORD_W)) lat_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_stb  (pin_rise[P_LOAD]),
        .word      (word),
        .r_lat     (r_lat),
        .c_lat     (c_lat),
        .f_lat     (f_lat),
        .rst_pulse (ctr_rst_pulse)
    );

    assign r_div      = r_lat.rdiv;
    assign r_abw      = r_lat.abw;
    assign r_test     = r_lat.test;
    assign r_ldp      = r_lat.ldp;
    assign ab_a       = c_lat.a;
    assign ab_b       = c_lat.b;
    assign ab_gain    = c_lat.gain;
    assign fn_cnt_rst = f_lat.cnt_rst;
    assign fn_pd1     = f_lat.pd1;
    assign fn_mux     = f_lat.mux;
    assign fn_pol     = f_lat.pol;
    assign fn_cp3s    = f_lat.cp3s;
    assign fn_fl_en   = f_lat.fl_en;
    assign fn_fl_mode = f_lat.fl_mode;
    assign fn_timer   = f_lat.timer;
    assign fn_cur1    = f_lat.cur1;
    assign fn_cur2    = f_lat.cur2;
    assign fn_pd2     = f_lat.pd2;
    assign fn_presc   = f_lat.presc;

    // R10
    reset_state_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> !ctr_rst_pulse && r_div == '0 && ab_b == '0 && fn_presc == '0);
endmodule

// File: tb/ser_cfg_loader_tb.sv
module ser_cfg_loader_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
    logic [13:0] r_div; logic [1:0] r_abw, r_test; logic r_ldp;
    logic [5:0] ab_a; logic [12:0] ab_b; logic ab_gain;
    logic fn_cnt_rst, fn_pd1, fn_pol, fn_cp3s, fn_fl_en, fn_fl_mode, fn_pd2;
    logic [2:0] fn_mux, fn_cur1, fn_cur2; logic [3:0] fn_timer; logic [1:0] fn_presc;
    logic ctr_rst_pulse;

    int checks = 0, failures = 0, pulses = 0, wide = 0;
    logic prev_pulse = 1'b0;
    logic [18:0] exp_r = '0;
    logic [19:0] exp_c = '0;
    logic [21:0] exp_f = '0;

    always #5 clk = ~clk;

    ser_cfg_loader dut_i (.*);

    always @(negedge clk) begin
        if (ctr_rst_pulse) pulses++;
        if (ctr_rst_pulse && prev_pulse) wide++;
        prev_pulse = ctr_rst_pulse;
    end

    // {expected pulse, word}
    localparam logic [24:0] VEC [10] = '{
        {1'b0, 24'h006415},  // count write before any init: quiet (R8)
        {1'b0, 24'h12FFFC},  // divider 16383, abw 2, ldp 1
        {1'b0, 24'hA5A5A6},  // function write
        {1'b1, 24'h5A5A5B},  // init
        {1'b1, 24'h3FFFFD},  // first count after init
        {1'b0, 24'h000301},  // second count: quiet
        {1'b0, 24'hED0004},  // divider 1, top bits ignored
        {1'b1, 24'hFFFFFF},  // init again
        {1'b0, 24'h000002},  // function write keeps arming
        {1'b1, 24'hC06415}   // count: pulses, top bits ignored
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic report();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic shift_bit(input logic b);
        ser_data = b;
        repeat (3) @(negedge clk);
        ser_clk = 1'b1;
        repeat (3) @(negedge clk);
        ser_clk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic shift_word(input logic [23:0] w);
        for (int i = 23; i >= 0; i--) shift_bit(w[i]);
    endtask

    task automatic pulse_load();
        ser_load = 1'b1;
        repeat (6) @(negedge clk);
        ser_load = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    function automatic void model(input logic [23:0] w);
        case (w[1:0])
            2'd0: exp_r = w[20:2];
            2'd1: exp_c = w[21:2];
            default: exp_f = w[23:2];
        endcase
    endfunction

    task automatic check_all(input string tag);
        chk({tag, " R3 divider"}, {13'd0, r_ldp, r_test, r_abw, r_div}, {13'd0, exp_r});
        chk({tag, " R4 count"}, {12'd0, ab_gain, ab_b, ab_a}, {12'd0, exp_c});
        chk({tag, " R5 function"},
            {10'd0, fn_presc, fn_pd2, fn_cur2, fn_cur1, fn_timer, fn_fl_mode, fn_fl_en,
             fn_cp3s, fn_pol, fn_mux, fn_pd1, fn_cnt_rst}, {10'd0, exp_f});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        int p0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R10 reset state
        check_all("R10");
        chk("R10 pulse", {31'd0, ctr_rst_pulse}, 32'd0);

        // Table walk: R1 R2 R6 R7 R8
        for (int k = 0; k < 10; k++) begin
            p0 = pulses;
            shift_word(VEC[k][23:0]);
            pulse_load();
            model(VEC[k][23:0]);
            check_all("R2");
            chk("R6/R7/R8 pulse count", pulses - p0, {31'd0, VEC[k][24]});
        end
        chk("R11 pulse width", wide, 0);

        // R1: leading extra bits dropped
        shift_bit(1'b1); shift_bit(1'b0); shift_bit(1'b1); shift_bit(1'b1);
        shift_word(24'h0A3C05);
        pulse_load();
        model(24'h0A3C05);
        check_all("R1 extra bits");

        // R9: writes accepted while powered down
        shift_word(24'h20000A);
        pulse_load();
        model(24'h20000A);
        chk("R9 pd bits set", {30'd0, fn_pd2, fn_pd1}, 32'd3);
        shift_word(24'h00000C);
        pulse_load();
        model(24'h00000C);
        chk("R9 divider while down", {18'd0, r_div}, 32'd3);

        // R12: load held high, second word shifted does not transfer
        shift_word(24'h000014);
        ser_load = 1'b1;
        repeat (6) @(negedge clk);
        model(24'h000014);
        shift_word(24'h001F09);
        repeat (6) @(negedge clk);
        check_all("R12 held");
        ser_load = 1'b0;
        repeat (3) @(negedge clk);
        pulse_load();
        model(24'h001F09);
        chk("R12 next edge", {26'd0, ab_a}, 32'd2);
        chk("R12 next edge b", {19'd0, ab_b}, 32'd31);
        chk("R11 pulse width end", wide, 0);
        report();
    end
endmodule